// File: doc/BRIEF.md
# General-Purpose I/O Port with Read-Relative Interrupts

This block is one 8-bit general-purpose I/O port with a small CPU register interface. Each pin's output comes from one of two sources. The first is a CPU-written output data register. The second is an alternate internal data input, which is chosen when a hardware function claims the pin or when software sets that pin's bypass bit. Two per-pin drive-mode registers are set apart from the bypass choice and go straight out to the pad configuration. Pin inputs pass through a two-flop synchronizer before any logic uses them.

Interrupts are level requests gated by a per-pin enable. One global mode bit picks the trigger condition for every pin at once. In level mode a pin requests while it is low. In change mode a pin requests while its level differs from a snapshot. That snapshot is taken only when the CPU reads the pin register, so software sets the polarity of each pin by reading the port in its service routine. If software skips the read, the polarity stays where it was. All pin requests are ORed onto one interrupt line.

Register map, as the 3-bit offset on `cpu_addr`:
- 0: a read returns the synchronized pins and takes the snapshot; a write sets the output data register.
- 1: interrupt enables.
- 2: bypass enables.
- 3: drive-mode low.
- 4: drive-mode high.
- 5: bit 0 is the change-mode bit.
- 6 and 7 read as zero.

Top module: `gpio_rdrel_port`

## Requirements
- R1: After reset, every register is zero. The snapshot is zero, `irq` is 0, `pin_out` is 0 and both drive-mode outputs are 0.
- R2: A pin whose interrupt-enable bit (offset 1) is 0 never drives `irq`, in either mode.
- R3: With the mode bit (offset 5, bit 0) at 0, an enabled pin holds `irq` high while its synchronized level is 0.
- R4: With the mode bit at 1, an enabled pin holds `irq` high while its synchronized level differs from its snapshot bit. A snapshot of 0 means the pin triggers on high, and a snapshot of 1 means it triggers on low.
- R5: The snapshot changes only on a CPU read of offset 0. Writes to any offset, and reads of any other offset, leave it unchanged.
- R6: A read of offset 0 returns the synchronized pin levels in the cycle of the read strobe. A pin change shows there two clock edges after it is applied, and the same value is stored as the snapshot at that edge.
- R7: `pin_out[i]` equals `alt_data[i]` when `func_en[i]` or bypass bit i (offset 2) is 1. Otherwise it equals bit i of the output data register.
- R8: Offsets 3 and 4 drive `pad_mode_lo` and `pad_mode_hi` directly and do not depend on the bypass or function selection.
- R9: Offsets 1 to 4 read back the written byte. Offset 5 reads back only bit 0, with the other bits 0. Offsets 6 and 7 read 0.
- R10: `irq` is the OR of all pins' enabled conditions. It drops as soon as no pin meets its condition.
- R11: Changing the mode bit changes the trigger condition of all pins together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 3 | Register offset |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the strobe cycle |
| pin_in | input | 8 | Asynchronous pin levels |
| alt_data | input | 8 | Alternate internal output data |
| func_en | input | 8 | Per-pin claim by an internal hardware function |
| pin_out | output | 8 | Per-pin output data |
| pad_mode_lo | output | 8 | Drive-mode low register |
| pad_mode_hi | output | 8 | Drive-mode high register |
| irq | output | 1 | Combined level interrupt request |

## Verification
A wrong snapshot shows at the ports at the next read. In change mode it shows sooner, as an `irq` that is raised or cleared in the wrong direction right after the read edge. A snapshot updated by the wrong access is caught because `irq` is checked after writes and after reads of other offsets, with the pin held at a level that would flip the request. Errors in the synchronizer depth or in the output source selection show within two cycles on `cpu_rdata`, `irq` or `pin_out`.

// File: rtl/gpio_rdrel_pkg.sv
package gpio_rdrel_pkg;

    localparam int PORT_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int SYNC_LEN = 2;

    typedef logic [PORT_W-1:0] port_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        OFS_PINS = 3'd0,
        OFS_IEN  = 3'd1,
        OFS_BYP  = 3'd2,
        OFS_DMLO = 3'd3,
        OFS_DMHI = 3'd4,
        OFS_CFG  = 3'd5
    } reg_ofs_e;

    typedef struct packed {
        port_vec_t dout;
        port_vec_t ien;
        port_vec_t byp;
        port_vec_t dm_lo;
        port_vec_t dm_hi;
        logic      chg_mode;
    } port_cfg_t;

    // Per-pin trigger condition before enable gating
    function automatic port_vec_t pin_trigger(input port_vec_t lvl,
                                              input port_vec_t snap,
                                              input logic chg);
        return chg ? (lvl ^ snap) : ~lvl;
    endfunction

endpackage

// File: rtl/gpio_rdrel_sync.sv
module gpio_rdrel_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/gpio_rdrel_regs.sv
module gpio_rdrel_regs
    import gpio_rdrel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  port_vec_t         cpu_wdata,
    input  port_vec_t         pins_sync,
    output port_cfg_t         cfg,
    output port_vec_t         snap,
    output port_vec_t         cpu_rdata
);
    logic pins_read;
    assign pins_read = cpu_rd && (cpu_addr == OFS_PINS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cpu_wr) begin
            case (reg_ofs_e'(cpu_addr))
                OFS_PINS: cfg.dout     <= cpu_wdata;
                OFS_IEN:  cfg.ien      <= cpu_wdata;
                OFS_BYP:  cfg.byp      <= cpu_wdata;
                OFS_DMLO: cfg.dm_lo    <= cpu_wdata;
                OFS_DMHI: cfg.dm_hi    <= cpu_wdata;
                OFS_CFG:  cfg.chg_mode <= cpu_wdata[0];
                default:  ;
            endcase
        end
    end

    // Snapshot taken only by a read of the pin register
    always_ff @(posedge clk) begin
        if (rst) snap <= '0;
        else if (pins_read) snap <= pins_sync;
    end

    always_comb begin
        case (reg_ofs_e'(cpu_addr))
            OFS_PINS: cpu_rdata = pins_sync;
            OFS_IEN:  cpu_rdata = cfg.ien;
            OFS_BYP:  cpu_rdata = cfg.byp;
            OFS_DMLO: cpu_rdata = cfg.dm_lo;
            OFS_DMHI: cpu_rdata = cfg.dm_hi;
            OFS_CFG:  cpu_rdata = {{(PORT_W-1){1'b0}}, cfg.chg_mode};
            default:  cpu_rdata = '0;
        endcase
    end

    // R5: snapshot holds unless the pin register is read
    assert_snap_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rd && cpu_addr == OFS_PINS) |=> $stable(snap));

    // R6: snapshot equals the sample presented during the read
    assert_snap_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_addr == OFS_PINS) |=> snap == $past(cpu_rdata));

endmodule

// File: rtl/gpio_rdrel_irq.sv
module gpio_rdrel_irq
    import gpio_rdrel_pkg::*;
(
    input  port_vec_t lvl,
    input  port_vec_t snap,
    input  port_vec_t ien,
    input  logic      chg_mode,
    output logic      irq
);
    port_vec_t trig;
    port_vec_t hit;

    assign trig = pin_trigger(lvl, snap, chg_mode);

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        assign hit[i] = ien[i] & trig[i];
    end

    assign irq = |hit;

endmodule

// File: rtl/gpio_rdrel_outmux.sv
module gpio_rdrel_outmux
    import gpio_rdrel_pkg::*;
(
    input  port_vec_t dout,
    input  port_vec_t alt_data,
    input  port_vec_t func_en,
    input  port_vec_t byp,
    output port_vec_t pin_out
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        logic use_alt;
        assign use_alt    = func_en[i] | byp[i];
        assign pin_out[i] = use_alt ? alt_data[i] : dout[i];
    end

endmodule

// File: rtl/gpio_rdrel_port.sv
module gpio_rdrel_port
    import gpio_rdrel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [PORT_W-1:0] cpu_wdata,
    output logic [PORT_W-1:0] cpu_rdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] alt_data,
    input  logic [PORT_W-1:0] func_en,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pad_mode_lo,
    output logic [PORT_W-1:0] pad_mode_hi,
    output logic              irq
);
    port_vec_t pins_sync;
    port_vec_t snap;
    port_cfg_t cfg;

    gpio_rdrel_sync #(.W(PORT_W), .STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .d_sync  (pins_sync)
    );

    gpio_rdrel_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_wdata (cpu_wdata),
        .pins_sync (pins_sync),
        .cfg       (cfg),
        .snap      (snap),
        .cpu_rdata (cpu_rdata)
    );

    gpio_rdrel_irq u_irq (
        .lvl      (pins_sync),
        .snap     (snap),
        .ien      (cfg.ien),
        .chg_mode (cfg.chg_mode),
        .irq      (irq)
    );

    gpio_rdrel_outmux u_outmux (
        .dout     (cfg.dout),
        .alt_data (alt_data),
        .func_en  (func_en),
        .byp      (cfg.byp),
        .pin_out  (pin_out)
    );

    assign pad_mode_lo = cfg.dm_lo;
    assign pad_mode_hi = cfg.dm_hi;

    // R2: no enabled pin, no request
    assert_no_enable_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg.ien == '0) |-> !irq);

    // R3: level mode requests on any enabled low pin
    assert_level_mode_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg.chg_mode && ((cfg.ien & ~pins_sync) != '0)) |-> irq);

    // R4: change mode requests only when an enabled pin differs from its snapshot
    assert_change_mode_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg.chg_mode && ((cfg.ien & (pins_sync ^ snap)) == '0)) |-> !irq);

    // R7: a pin claimed by a hardware function carries the alternate bit
    assert_func_alt_R7: assert property (@(posedge clk) disable iff (rst)
        ((pin_out ^ alt_data) & func_en) == '0);

endmodule

// File: tb/gpio_rdrel_port_tb.sv
module gpio_rdrel_port_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] cpu_addr;
    logic       cpu_wr, cpu_rd;
    logic [7:0] cpu_wdata, cpu_rdata;
    logic [7:0] pin_in, alt_data, func_en;
    logic [7:0] pin_out, pad_mode_lo, pad_mode_hi;
    logic       irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    gpio_rdrel_port u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pin_in(pin_in),
        .alt_data(alt_data), .func_en(func_en), .pin_out(pin_out),
        .pad_mode_lo(pad_mode_lo), .pad_mode_hi(pad_mode_hi), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [7:0] d;
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 pad_mode_lo", pad_mode_lo, 8'h00);
        check("R1 pad_mode_hi", pad_mode_hi, 8'h00);
        for (int a = 1; a <= 5; a++) begin
            cpu_read(a[2:0], d);
            check("R1 register zero", d, 8'h00);
        end
    endtask

    task automatic test_readback();
        logic [7:0] d;
        cpu_write(3'd1, 8'hA5); cpu_read(3'd1, d); check("R9 ien readback", d, 8'hA5);
        cpu_write(3'd2, 8'h3C); cpu_read(3'd2, d); check("R9 bypass readback", d, 8'h3C);
        cpu_write(3'd5, 8'hFE); cpu_read(3'd5, d); check("R9 cfg bit0 only", d, 8'h00);
        cpu_write(3'd5, 8'hFF); cpu_read(3'd5, d); check("R9 cfg readback", d, 8'h01);
        cpu_read(3'd6, d); check("R9 offset 6 zero", d, 8'h00);
        cpu_read(3'd7, d); check("R9 offset 7 zero", d, 8'h00);
        cpu_write(3'd1, 8'h00); cpu_write(3'd2, 8'h00); cpu_write(3'd5, 8'h00);
    endtask

    task automatic test_drive_modes();
        cpu_write(3'd3, 8'h3C);
        cpu_write(3'd4, 8'hC3);
        check("R8 pad_mode_lo", pad_mode_lo, 8'h3C);
        check("R8 pad_mode_hi", pad_mode_hi, 8'hC3);
        cpu_write(3'd2, 8'hFF);
        func_en = 8'hFF;
        @(negedge clk);
        check("R8 lo independent of bypass", pad_mode_lo, 8'h3C);
        check("R8 hi independent of bypass", pad_mode_hi, 8'hC3);
        func_en = 8'h00;
        cpu_write(3'd2, 8'h00);
    endtask

    task automatic test_outmux();
        alt_data = 8'hF0;
        cpu_write(3'd0, 8'h5A);
        check("R7 data register source", pin_out, 8'h5A);
        cpu_write(3'd2, 8'h0F);
        check("R7 bypass selects alt", pin_out, 8'h50);
        func_en = 8'h30;
        #1 check("R7 function claim selects alt", pin_out, 8'h70);
        func_en = 8'h00;
        cpu_write(3'd2, 8'h00);
        check("R7 back to data register", pin_out, 8'h5A);
    endtask

    task automatic test_disabled();
        logic [7:0] d;
        cpu_write(3'd1, 8'h00);
        set_pins(8'h00);
        check("R2 level mode disabled", {7'b0, irq}, 8'h00);
        cpu_read(3'd0, d);
        cpu_write(3'd5, 8'h01);
        set_pins(8'hFF);
        check("R2 change mode disabled", {7'b0, irq}, 8'h00);
        cpu_write(3'd5, 8'h00);
    endtask

    task automatic test_level_mode();
        set_pins(8'hFF);
        cpu_write(3'd1, 8'h01);
        check("R3 high pin no request", {7'b0, irq}, 8'h00);
        set_pins(8'hFE);
        check("R3 low pin requests", {7'b0, irq}, 8'h01);
        set_pins(8'hFF);
        check("R10 request clears", {7'b0, irq}, 8'h00);
        cpu_write(3'd1, 8'h81);
        set_pins(8'h7E);
        check("R10 two pins low", {7'b0, irq}, 8'h01);
        set_pins(8'hFE);
        check("R10 one pin still low", {7'b0, irq}, 8'h01);
        set_pins(8'hFF);
        check("R10 none low", {7'b0, irq}, 8'h00);
    endtask

    task automatic test_change_mode();
        logic [7:0] d;
        cpu_write(3'd1, 8'h01);
        cpu_write(3'd5, 8'h01);
        set_pins(8'h00);
        cpu_read(3'd0, d);
        check("R6 read returns pins", d, 8'h00);
        check("R4 matches snapshot 0", {7'b0, irq}, 8'h00);
        @(negedge clk); pin_in = 8'h01;
        @(negedge clk);
        check("R6 one edge not yet visible", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R4 snapshot 0 triggers high", {7'b0, irq}, 8'h01);
        cpu_read(3'd0, d);
        check("R6 read returns new pins", d, 8'h01);
        check("R4 snapshot 1 clears", {7'b0, irq}, 8'h00);
        set_pins(8'h00);
        check("R4 snapshot 1 triggers low", {7'b0, irq}, 8'h01);
        cpu_write(3'd0, 8'h00);
        cpu_read(3'd1, d);
        cpu_read(3'd5, d);
        check("R5 snapshot kept after other accesses", {7'b0, irq}, 8'h01);
        set_pins(8'h01);
        check("R5 polarity unchanged without read", {7'b0, irq}, 8'h00);
    endtask

    task automatic test_global_mode();
        logic [7:0] d;
        cpu_write(3'd1, 8'hFF);
        set_pins(8'h00);
        cpu_read(3'd0, d);
        cpu_write(3'd5, 8'h01);
        check("R11 change mode all match", {7'b0, irq}, 8'h00);
        cpu_write(3'd5, 8'h00);
        check("R11 level mode all low", {7'b0, irq}, 8'h01);
        set_pins(8'hFF);
        check("R11 level mode all high", {7'b0, irq}, 8'h00);
        cpu_write(3'd5, 8'h01);
        check("R11 change mode all differ", {7'b0, irq}, 8'h01);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cpu_addr = '0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_wdata = '0;
        pin_in = 8'hFF; alt_data = '0; func_en = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_readback();
        test_drive_modes();
        test_outmux();
        test_disabled();
        test_level_mode();
        test_change_mode();
        test_global_mode();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule